// File: doc/BRIEF.md
# Block Address Translation Matcher

This block compares a 32-bit effective address against four block-translation register pairs and returns a physical address when one of them matches. Each pair has an upper word, which holds the block's effective base, and a lower word, which holds the physical base, a size code and an enable bit. There are two independent banks of four pairs. One bank serves instruction fetches and the other serves data accesses, and an access-type flag on the request picks the bank.

Software loads the pairs through a single-word write port. Each write names the bank, the pair number and the word (upper or lower). A lookup is issued with a valid/ready handshake. The hit flag, the number of the winning pair and the translated address come back registered, one cycle after the request. When more than one pair matches, the pair with the lowest number wins.

Top module: `bat_xlate_top`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is low and every pair in both banks is disabled, so any lookup misses.
- R2: `req_ready` is high whenever the block is out of reset. A request accepted on a clock edge gives `rsp_valid` high for exactly the next cycle. Without a request, `rsp_valid` is low the next cycle and `rsp_hit` is low.
- R3: A pair can match only when bit 6 of its lower word is 1.
- R4: The comparison mask is 0xFFFE0000 with bits 22:17 cleared wherever the lower word's bits 5:0 are 1. A pair matches when (address AND mask) equals (upper word AND mask).
- R5: On a hit, `rsp_paddr` equals (lower word AND 0xFFFE0000) OR (address AND 0x007FFFFF).
- R6: When several pairs match, the pair with the lowest number is reported in `rsp_idx` and supplies the address.
- R7: `req_is_insn`=1 looks up the instruction bank (`wr_bank`=1) and `req_is_insn`=0 looks up the data bank (`wr_bank`=0). Entries in the other bank have no effect on the result.
- R8: A lookup with no matching pair returns `rsp_hit`=0, `rsp_idx`=0 and `rsp_paddr`=0.
- R9: A register write on a given edge is not seen by a request sampled on the same edge. It is seen by a request sampled on the next edge.
- R10: `wr_sel_lo`=1 writes the lower word and `wr_sel_lo`=0 writes the upper word. Only the addressed word of the addressed pair in the addressed bank changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_addr | input | 32 | Effective address to translate |
| req_is_insn | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 1 | Bank to write: 1 = instruction, 0 = data |
| wr_idx | input | 2 | Pair number to write |
| wr_sel_lo | input | 1 | 1 = lower word, 0 = upper word |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A pair matched |
| rsp_idx | output | 2 | Number of the winning pair |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The directed cases cover the following:
- Addresses that differ from a pair's base in only one masked bit, to show the mask, the enable bit and the size code each change the outcome.
- Identical pairs at several positions, to separate lowest-number priority from any other ordering.
- Entries loaded into one bank only, to show the bank selection.
- A write issued on the same edge as a lookup, to pin the write-to-use timing.

Random lookups are also run against a random table. About half of these addresses are formed inside a programmed block, and bits 22:17 come from both the address and the physical base, which exercises the OR overlap in the translated result.

// File: rtl/bat_pkg.sv
// Package: shared constants for the block-address translation matcher.
// Assumes a 32-bit address space and a 17-bit minimum block granule.
package bat_pkg;
    localparam int ADDR_W    = 32;
    localparam int GRAN_LSB  = 17;    // lowest compared address bit
    localparam int LEN_W     = 6;     // size code width in the lower word
    localparam int EN_BIT    = 6;     // enable bit position in the lower word
    localparam int OFFS_W    = 23;    // address bits always passed through
    localparam logic [ADDR_W-1:0] BASE_MASK = 32'hFFFE_0000;
endpackage

// File: rtl/bat_regbank.sv
// Register bank: holds upper/lower words for two banks of NPAIR pairs.
// Writes land on the clock edge. The read side presents the bank chosen
// by the lookup's access type. Reset clears every word, which disables all pairs.
module bat_regbank #(
    parameter int NPAIR = 4,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NPAIR)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_bank,
    input  logic [IW-1:0]             wr_idx,
    input  logic                      wr_sel_lo,
    input  logic [DW-1:0]             wr_data,
    input  logic                      rd_bank,
    output logic [NPAIR-1:0][DW-1:0]  rd_hi,
    output logic [NPAIR-1:0][DW-1:0]  rd_lo
);
    logic [1:0][NPAIR-1:0][DW-1:0] hi_q;
    logic [1:0][NPAIR-1:0][DW-1:0] lo_q;

    // Store one word per write; clear all words on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            if (wr_sel_lo) lo_q[wr_bank][wr_idx] <= wr_data;
            else           hi_q[wr_bank][wr_idx] <= wr_data;
        end
    end

    // Present the bank requested by the lookup.
    always_comb begin
        rd_hi = hi_q[rd_bank];
        rd_lo = lo_q[rd_bank];
    end
endmodule

// File: rtl/bat_pair_match.sv
// Pair matcher: decides whether one pair covers the address and forms
// the translated address for it. Pure combinational logic.
module bat_pair_match
    import bat_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] hi_word,
    input  logic [ADDR_W-1:0] lo_word,
    output logic              hit,
    output logic [ADDR_W-1:0] paddr
);
    logic [ADDR_W-1:0] size_bits;
    logic [ADDR_W-1:0] cmp_mask;

    // Build the comparison mask from the size code and test the enable bit.
    always_comb begin
        size_bits = ADDR_W'(lo_word[LEN_W-1:0]) << GRAN_LSB;
        cmp_mask  = BASE_MASK & ~size_bits;
        hit       = lo_word[EN_BIT] && ((addr & cmp_mask) == (hi_word & cmp_mask));
        paddr     = (lo_word & BASE_MASK) | {{(ADDR_W-OFFS_W){1'b0}}, addr[OFFS_W-1:0]};
    end
endmodule

// File: rtl/bat_prio_pick.sv
// Priority pick: reports whether any pair hit and the lowest hitting index.
module bat_prio_pick #(
    parameter int NPAIR = 4,
    localparam int IW   = $clog2(NPAIR)
) (
    input  logic [NPAIR-1:0] hits,
    output logic             any,
    output logic [IW-1:0]    idx
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = NPAIR - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/bat_xlate_top.sv
// Block-address translation matcher top. It looks up the address against the
// selected bank's pairs and registers hit, index and address one cycle
// after an accepted request. It assumes no back-pressure on the response side.
module bat_xlate_top
    import bat_pkg::*;
#(
    parameter int NPAIR = 4,
    localparam int IW   = $clog2(NPAIR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_insn,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_sel_lo,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IW-1:0]     rsp_idx,
    output logic [ADDR_W-1:0] rsp_paddr
);
    logic [NPAIR-1:0][ADDR_W-1:0] cur_hi;
    logic [NPAIR-1:0][ADDR_W-1:0] cur_lo;
    logic [NPAIR-1:0][ADDR_W-1:0] cand_pa;
    logic [NPAIR-1:0]             pair_hit;
    logic                         any_hit;
    logic [IW-1:0]                win_idx;
    logic                         accept;

    bat_regbank #(.NPAIR(NPAIR), .DW(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .wr_sel_lo (wr_sel_lo),
        .wr_data   (wr_data),
        .rd_bank   (req_is_insn),
        .rd_hi     (cur_hi),
        .rd_lo     (cur_lo)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        bat_pair_match u_match (
            .addr    (req_addr),
            .hi_word (cur_hi[g]),
            .lo_word (cur_lo[g]),
            .hit     (pair_hit[g]),
            .paddr   (cand_pa[g])
        );
    end

    bat_prio_pick #(.NPAIR(NPAIR)) u_pick (
        .hits (pair_hit),
        .any  (any_hit),
        .idx  (win_idx)
    );

    // Ready follows reset: the lookup path never stalls.
    always_comb begin
        req_ready = rst_n;
        accept    = req_valid && req_ready;
    end

    // Register the result; misses and idle cycles drive zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && any_hit;
            rsp_idx   <= (accept && any_hit) ? win_idx : '0;
            rsp_paddr <= (accept && any_hit) ? cand_pa[win_idx] : '0;
        end
    end
endmodule

// File: rtl/bat_xlate_chk.sv
// Checker: timing and output-shape properties of the translation matcher.
module bat_xlate_chk #(
    parameter int NPAIR = 4,
    localparam int IW   = $clog2(NPAIR)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [31:0]   req_addr,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic [IW-1:0] rsp_idx,
    input logic [31:0]   rsp_paddr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);                         // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit));                        // R2
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == 32'h0 && rsp_idx == '0)); // R8
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[16:0] == $past(req_addr[16:0])));         // R5
    AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready);                                                      // R2
endmodule

bind bat_xlate_top bat_xlate_chk #(.NPAIR(NPAIR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx),
    .rsp_paddr (rsp_paddr)
);

// File: tb/bat_xlate_top_test.sv
`timescale 1ns/1ps
module bat_xlate_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_is_insn = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_sel_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_idx;
    logic [31:0] rsp_paddr;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] m_hi [2][4];
    logic [31:0] m_lo [2][4];

    always #2 clk = ~clk;

    bat_xlate_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_is_insn(req_is_insn), .wr_en(wr_en),
        .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_sel_lo(wr_sel_lo), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_paddr(rsp_paddr)
    );

    function automatic bit pair_hits(logic [31:0] hi, logic [31:0] lo, logic [31:0] a);
        logic [31:0] m = 32'hFFFE0000 & ~({26'b0, lo[5:0]} << 17);
        return lo[6] && ((a & m) == (hi & m));
    endfunction

    // Expected {hit, idx, paddr} from the bench model.
    function automatic logic [34:0] expect_of(bit bank, logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            if (pair_hits(m_hi[bank][i], m_lo[bank][i], a))
                return {1'b1, 2'(i), (m_lo[bank][i] & 32'hFFFE0000) | (a & 32'h007FFFFF)};
        end
        return 35'h0;
    endfunction

    task automatic check(string req, logic [34:0] act, logic [34:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual hit=%0b idx=%0d pa=%h expected hit=%0b idx=%0d pa=%h",
                     req, act[34], act[33:32], act[31:0], exp[34], exp[33:32], exp[31:0]);
        end
    endtask

    task automatic wr(bit bank, int idx, bit lo, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_bank = bank; wr_idx = 2'(idx); wr_sel_lo = lo; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (lo) m_lo[bank][idx] = d; else m_hi[bank][idx] = d;
    endtask

    task automatic lookup(string req, bit bank, logic [31:0] a);
        logic [34:0] e;
        @(negedge clk);
        req_valid = 1; req_is_insn = bank; req_addr = a;
        e = expect_of(bank, a);
        @(negedge clk);
        req_valid = 0;
        check(req, {rsp_hit, rsp_idx, rsp_paddr}, e);
        check(req, {34'h0, rsp_valid}, 35'h1);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < 2; b++) for (int i = 0; i < 4; i++) begin
            m_hi[b][i] = '0; m_lo[b][i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", {34'h0, rsp_valid}, 35'h0);
        rst_n = 1;
        @(negedge clk);
        check("R2 ready", {34'h0, req_ready}, 35'h1);
        lookup("R1 empty data bank", 0, 32'h0000_0000);
        lookup("R1 empty insn bank", 1, 32'h1234_5678);
        @(negedge clk);
        check("R2 idle", {33'h0, rsp_valid, rsp_hit}, 35'h0);

        // R3: enable bit
        wr(0, 0, 0, 32'h4000_0000);
        wr(0, 0, 1, 32'h8002_0000);           // disabled
        lookup("R3 disabled pair", 0, 32'h4000_1234);
        wr(0, 0, 1, 32'h8002_0040);           // enabled, size 0
        lookup("R3 enabled pair", 0, 32'h4000_1234);
        // R4: mask edges
        lookup("R4 bit17 differs", 0, 32'h4002_1234);
        wr(0, 0, 1, 32'h8002_0041);           // size code clears bit 17
        lookup("R4 bit17 masked", 0, 32'h4002_1234);
        lookup("R4 bit18 differs", 0, 32'h4004_0000);
        wr(0, 0, 1, 32'h8002_007F);           // 8 MB block
        lookup("R4 full size", 0, 32'h407F_FFFF);
        lookup("R5 overlap OR", 0, 32'h4040_0001);
        lookup("R4 bit23 differs", 0, 32'h4080_0000);
        // R6: priority
        wr(0, 2, 0, 32'h4000_0000); wr(0, 2, 1, 32'hC000_0040);
        wr(0, 3, 0, 32'h4000_0000); wr(0, 3, 1, 32'hE000_0040);
        lookup("R6 lowest wins", 0, 32'h4000_0010);
        wr(0, 0, 1, 32'h0);
        lookup("R6 next lowest", 0, 32'h4000_0010);
        // R7: bank separation
        lookup("R7 insn bank empty", 1, 32'h4000_0010);
        wr(1, 1, 0, 32'h4000_0000); wr(1, 1, 1, 32'h1230_0040);
        lookup("R7 insn bank hit", 1, 32'h4000_0010);
        lookup("R7 data unaffected", 0, 32'h4000_0010);
        // R10: upper-word write leaves lower intact
        wr(1, 1, 0, 32'h6000_0000);
        lookup("R10 hi rewrite new", 1, 32'h6000_0004);
        lookup("R10 hi rewrite old", 1, 32'h4000_0004);
        // R9: write on same edge as request
        @(negedge clk);
        wr_en = 1; wr_bank = 1; wr_idx = 0; wr_sel_lo = 0; wr_data = 32'h7000_0000;
        req_valid = 1; req_is_insn = 1; req_addr = 32'h6000_0004;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        check("R9 same-edge old", {rsp_hit, rsp_idx, rsp_paddr}, expect_of(1, 32'h6000_0004));
        m_hi[1][0] = 32'h7000_0000;
        @(negedge clk);
        wr_en = 1; wr_sel_lo = 1; wr_data = 32'h9000_0040;
        req_valid = 1; req_addr = 32'h7000_0008;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        check("R9 same-edge miss", {rsp_hit, rsp_idx, rsp_paddr}, 35'h0);
        m_lo[1][0] = 32'h9000_0040;
        lookup("R9 next-edge hit", 1, 32'h7000_0008);
        lookup("R8 miss zeros", 1, 32'hF000_0000);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            bit b;
            int k;
            logic [31:0] a;
            if (n % 10 == 0) begin
                b = 1'($urandom);
                k = int'($urandom % 4);
                wr(b, k, 0, $urandom);
                wr(b, k, 1, ($urandom & 32'hFFFE007F) | (($urandom % 4 != 0) ? 32'h40 : 32'h0));
            end
            b = 1'($urandom);
            k = int'($urandom % 4);
            if ($urandom % 2 == 0) a = m_hi[b][k] ^ ($urandom & 32'h007F_FFFF);
            else a = $urandom;
            lookup("R4 R5 R6 R7 random", b, a);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end
endmodule